// File: doc/BRIEF.md
# Vector Slice Miss and Retry Controller

This controller sits between a vector memory pipeline and the second-level cache and follows every slice of conflict-free element addresses from the moment it is sent to the cache until the cache reports a hit for it. A slice is all-or-nothing. A miss never completes part of a slice. Instead, the slice stays in a small miss address file and sleeps there until a fill for its line comes back. It then joins a first-in first-out retry queue and is sent to the cache again. Each entry keeps a slice ID, a line address and a saturating count of how many times it has been reissued.

An entry is reserved when a new slice is accepted. Every request the block sends carries the index of its entry as a tag, and the cache returns that tag with its hit or miss verdict. A pending retry always wins the single request slot over a new slice. An entry can end up missing once more after it has already been reissued `PANIC_LIM` times. When that happens, the controller makes that entry the single owner of a panic state. In panic, new slices are refused with a nack, and only the owner may be reissued. Other woken slices wait until the owner gets its hit, which ends panic and lets the held retries drain.

Top module: `vslice_miss_ctl`

## Requirements
- R1: During and after reset, `req_valid`, `new_nack`, `done_valid` and `panic` are 0, and `new_ready` is 1.
- R2: A new slice is accepted in a cycle where `new_valid` and `new_ready` are both 1. In the next cycle `req_valid` is 1 with `req_retry` 0, `req_id` and `req_addr` echo the inputs, and `req_tag` is the lowest-numbered free entry.
- R3: A hit response (`rsp_hit` 1) on a pending tag frees that entry. In the next cycle `done_valid` is 1 and `done_id` carries that slice's ID. A slice is reported done only on a hit.
- R4: A miss response parks the entry. It is not reissued until `fill_valid` arrives with `fill_addr` equal to its line address. A fill for any other address leaves it parked.
- R5: A single fill wakes every parked entry with that address. Woken entries enter the retry queue lowest index first, and retries leave the queue one per cycle in queue order, each as a request with `req_retry` 1 and the entry's tag, ID and address.
- R6: A fill that arrives in the same cycle as a miss response for the same address also wakes that entry.
- R7: When all `ENTRIES` entries are occupied, `new_ready` is 0 and no new request is sent.
- R8: When a retry is ready to go, `new_ready` is 0 and the retry takes the request slot. The new slice is accepted in a later cycle.
- R9: Each reissue of an entry adds one to its retry count, which saturates at 15, and allocation clears the count. A miss on an entry whose count is at least `PANIC_LIM` raises `panic` in the next cycle if `panic` is not already set. With the default of 4, that is the fifth consecutive miss of one slice.
- R10: While `panic` is 1, `new_ready` is 0, and every cycle with `new_valid` 1 produces `new_nack` 1 in the next cycle and no request.
- R11: While `panic` is 1, only the owner entry is reissued. It bypasses the queue as soon as its fill arrives, and other woken entries are held.
- R12: A hit response on the owner clears `panic` in the next cycle, and the held retries then issue.
- R13: A response whose tag is not pending has no effect. It produces no `done_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| new_valid | input | 1 | A new slice is offered |
| new_id | input | ID_W | Slice ID of the offered slice |
| new_addr | input | ADDR_W | Line address of the offered slice |
| new_ready | output | 1 | Offered slice is taken this cycle |
| new_nack | output | 1 | Offered slice of the previous cycle was refused by panic |
| req_valid | output | 1 | Request to the cache |
| req_retry | output | 1 | Request is a reissue |
| req_tag | output | TAG_W | Entry index carried by the request |
| req_id | output | ID_W | Slice ID of the request |
| req_addr | output | ADDR_W | Line address of the request |
| rsp_valid | input | 1 | Cache verdict for a tag |
| rsp_tag | input | TAG_W | Tag the verdict belongs to |
| rsp_hit | input | 1 | 1 hit, 0 miss |
| fill_valid | input | 1 | Line fill returned |
| fill_addr | input | ADDR_W | Address of the returned line |
| done_valid | output | 1 | A slice completed |
| done_id | output | ID_W | ID of the completed slice |
| panic | output | 1 | Panic state active |

## Verification
The bench goes after the windows where ordering decides the result. If a retry does not block `new_ready` in the cycle it becomes ready, a new slice steals the slot. If a miss and its fill land in the same cycle and that case is not handled, the slice is lost and the bench times out waiting for its retry. If a single fill releases only one of several matching slices, the rest sleep forever. Panic is driven to its exact threshold and one below it. A controller off by one enters panic a miss early or late. One that lets queued retries or new slices through during panic shows requests from non-owner tags, or a missing nack.

// File: rtl/vsm_pkg.sv
package vsm_pkg;
  typedef enum logic [2:0] {
    E_FREE = 3'd0,
    E_PEND = 3'd1,
    E_WAIT = 3'd2,
    E_WOKE = 3'd3,
    E_QUED = 3'd4
  } ent_st_e;
endpackage

// File: rtl/vsm_lowpick.sv
module vsm_lowpick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/vsm_retry_fifo.sv
module vsm_retry_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] count;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R5
  fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> (!full || pop));
  // R5
  fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/vsm_maf.sv
module vsm_maf
  import vsm_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 3,
  parameter int ID_W    = 8,
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               alloc_en,
  input  logic [TAG_W-1:0]   alloc_tag,
  input  logic [ID_W-1:0]    alloc_id,
  input  logic [ADDR_W-1:0]  alloc_addr,
  input  logic               rsp_en,
  input  logic [TAG_W-1:0]   rsp_tag,
  input  logic               rsp_hit,
  input  logic               fill_en,
  input  logic [ADDR_W-1:0]  fill_addr,
  input  logic               push_en,
  input  logic [TAG_W-1:0]   push_tag,
  input  logic               iss_en,
  input  logic [TAG_W-1:0]   iss_tag,
  output logic [ENTRIES-1:0] free_vec,
  output logic [ENTRIES-1:0] woke_vec,
  output logic [ENTRIES-1:0] pend_vec,
  output logic [ID_W-1:0]    iss_id,
  output logic [ADDR_W-1:0]  iss_addr,
  output logic [ID_W-1:0]    rsp_id,
  output logic [CNT_W-1:0]   rsp_cnt
);
  ent_st_e           st    [ENTRIES];
  logic [ID_W-1:0]   id_q  [ENTRIES];
  logic [ADDR_W-1:0] adr_q [ENTRIES];
  logic [CNT_W-1:0]  cnt_q [ENTRIES];

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_vec
      assign free_vec[g] = (st[g] == E_FREE);
      assign woke_vec[g] = (st[g] == E_WOKE);
      assign pend_vec[g] = (st[g] == E_PEND);
    end
  endgenerate

  assign iss_id   = id_q[iss_tag];
  assign iss_addr = adr_q[iss_tag];
  assign rsp_id   = id_q[rsp_tag];
  assign rsp_cnt  = cnt_q[rsp_tag];

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (alloc_en && alloc_tag == TAG_W'(i)) begin
        id_q[i]  <= alloc_id;
        adr_q[i] <= alloc_addr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) begin
        st[i]    <= E_FREE;
        cnt_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (alloc_en && alloc_tag == TAG_W'(i)) begin
          st[i]    <= E_PEND;
          cnt_q[i] <= '0;
        end else if (rsp_en && rsp_tag == TAG_W'(i)) begin
          if (rsp_hit)
            st[i] <= E_FREE;
          else if (fill_en && fill_addr == adr_q[i])
            st[i] <= E_WOKE;
          else
            st[i] <= E_WAIT;
        end else if (st[i] == E_WAIT && fill_en && fill_addr == adr_q[i]) begin
          st[i] <= E_WOKE;
        end else if (push_en && push_tag == TAG_W'(i)) begin
          st[i] <= E_QUED;
        end else if (iss_en && iss_tag == TAG_W'(i)) begin
          st[i] <= E_PEND;
          if (cnt_q[i] != '1) cnt_q[i] <= cnt_q[i] + 1'b1;
        end
      end
    end
  end

  // R2
  alloc_free_chk: assert property (@(posedge clk) disable iff (rst)
    alloc_en |-> (st[alloc_tag] == E_FREE));
  // R5
  push_woke_chk: assert property (@(posedge clk) disable iff (rst)
    push_en |-> (st[push_tag] == E_WOKE));
  // R11
  iss_ready_chk: assert property (@(posedge clk) disable iff (rst)
    iss_en |-> (st[iss_tag] == E_QUED || st[iss_tag] == E_WOKE));
endmodule

// File: rtl/vslice_miss_ctl.sv
module vslice_miss_ctl
  import vsm_pkg::*;
#(
  parameter int ENTRIES   = 8,
  parameter int ID_W      = 8,
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 4,
  parameter int PANIC_LIM = 4,
  localparam int TAG_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              new_valid,
  input  logic [ID_W-1:0]   new_id,
  input  logic [ADDR_W-1:0] new_addr,
  output logic              new_ready,
  output logic              new_nack,
  output logic              req_valid,
  output logic              req_retry,
  output logic [TAG_W-1:0]  req_tag,
  output logic [ID_W-1:0]   req_id,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  input  logic [TAG_W-1:0]  rsp_tag,
  input  logic              rsp_hit,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  output logic              done_valid,
  output logic [ID_W-1:0]   done_id,
  output logic              panic
);
  logic [ENTRIES-1:0] free_vec, woke_vec, pend_vec, own_mask, push_req;
  logic               free_any, push_any;
  logic [TAG_W-1:0]   free_tag, push_tag, retry_tag, owner_q;
  logic               panic_q, own_rdy, q_rdy, retry_go, new_go, rsp_ok;
  logic               fifo_empty, fifo_full;
  logic [TAG_W-1:0]   fifo_dout;
  logic [ID_W-1:0]    rd_id, rsp_id_r;
  logic [ADDR_W-1:0]  rd_addr;
  logic [CNT_W-1:0]   rsp_cnt;

  assign own_mask  = panic_q ? (ENTRIES'(1) << owner_q) : '0;
  assign push_req  = woke_vec & ~own_mask;
  assign own_rdy   = panic_q && woke_vec[owner_q];
  assign q_rdy     = !panic_q && !fifo_empty;
  assign retry_go  = own_rdy || q_rdy;
  assign retry_tag = own_rdy ? owner_q : fifo_dout;
  assign new_ready = !panic_q && free_any && !retry_go;
  assign new_go    = new_valid && new_ready;
  assign rsp_ok    = rsp_valid && pend_vec[rsp_tag];
  assign panic     = panic_q;

  vsm_lowpick #(.N(ENTRIES), .IW(TAG_W)) u_free_pick (
    .req(free_vec), .any(free_any), .idx(free_tag)
  );

  vsm_lowpick #(.N(ENTRIES), .IW(TAG_W)) u_push_pick (
    .req(push_req), .any(push_any), .idx(push_tag)
  );

  vsm_retry_fifo #(.DEPTH(ENTRIES), .W(TAG_W)) u_rq (
    .clk(clk), .rst(rst),
    .push(push_any), .din(push_tag),
    .pop(q_rdy), .dout(fifo_dout),
    .empty(fifo_empty), .full(fifo_full)
  );

  vsm_maf #(
    .ENTRIES(ENTRIES), .TAG_W(TAG_W), .ID_W(ID_W),
    .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_maf (
    .clk(clk), .rst(rst),
    .alloc_en(new_go), .alloc_tag(free_tag),
    .alloc_id(new_id), .alloc_addr(new_addr),
    .rsp_en(rsp_ok), .rsp_tag(rsp_tag), .rsp_hit(rsp_hit),
    .fill_en(fill_valid), .fill_addr(fill_addr),
    .push_en(push_any), .push_tag(push_tag),
    .iss_en(retry_go), .iss_tag(retry_tag),
    .free_vec(free_vec), .woke_vec(woke_vec), .pend_vec(pend_vec),
    .iss_id(rd_id), .iss_addr(rd_addr),
    .rsp_id(rsp_id_r), .rsp_cnt(rsp_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid  <= 1'b0;
      req_retry  <= 1'b0;
      req_tag    <= '0;
      req_id     <= '0;
      req_addr   <= '0;
      new_nack   <= 1'b0;
      done_valid <= 1'b0;
      done_id    <= '0;
      panic_q    <= 1'b0;
      owner_q    <= '0;
    end else begin
      req_valid  <= retry_go || new_go;
      req_retry  <= retry_go;
      req_tag    <= retry_go ? retry_tag : free_tag;
      req_id     <= retry_go ? rd_id : new_id;
      req_addr   <= retry_go ? rd_addr : new_addr;
      new_nack   <= new_valid && panic_q;
      done_valid <= rsp_ok && rsp_hit;
      done_id    <= rsp_id_r;
      if (rsp_ok) begin
        if (panic_q && rsp_hit && rsp_tag == owner_q) begin
          panic_q <= 1'b0;
        end else if (!panic_q && !rsp_hit && rsp_cnt >= CNT_W'(PANIC_LIM)) begin
          panic_q <= 1'b1;
          owner_q <= rsp_tag;
        end
      end
    end
  end

  // R3
  done_after_hit_chk: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> $past(rsp_valid && rsp_hit));
  // R8
  retry_first_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_retry) |-> $past(fifo_empty));
  // R9
  panic_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(panic_q) |-> $past(rsp_valid && !rsp_hit));
  // R10
  no_new_in_panic_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_retry) |-> !$past(panic_q));
  // R11
  owner_only_chk: assert property (@(posedge clk) disable iff (rst)
    (panic_q && $past(panic_q) && req_valid && req_retry) |-> (req_tag == owner_q));
  // R12
  panic_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(panic_q) |-> $past(rsp_valid && rsp_hit && rsp_tag == owner_q));
endmodule

// File: tb/vslice_miss_ctl_bench.sv
module vslice_miss_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        new_valid = 1'b0;
  logic [7:0]  new_id = '0;
  logic [31:0] new_addr = '0;
  logic        new_ready, new_nack;
  logic        req_valid, req_retry;
  logic [2:0]  req_tag;
  logic [7:0]  req_id;
  logic [31:0] req_addr;
  logic        rsp_valid = 1'b0;
  logic [2:0]  rsp_tag = '0;
  logic        rsp_hit = 1'b0;
  logic        fill_valid = 1'b0;
  logic [31:0] fill_addr = '0;
  logic        done_valid;
  logic [7:0]  done_id;
  logic        panic;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vslice_miss_ctl u_vslice_miss_ctl (
    .clk(clk), .rst(rst),
    .new_valid(new_valid), .new_id(new_id), .new_addr(new_addr),
    .new_ready(new_ready), .new_nack(new_nack),
    .req_valid(req_valid), .req_retry(req_retry), .req_tag(req_tag),
    .req_id(req_id), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_hit(rsp_hit),
    .fill_valid(fill_valid), .fill_addr(fill_addr),
    .done_valid(done_valid), .done_id(done_id), .panic(panic)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG_LIMIT) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG_LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic issue_new(input logic [7:0] id, input logic [31:0] addr,
                           input logic [2:0] exp_tag, input string rq);
    new_valid = 1'b1; new_id = id; new_addr = addr;
    #1;
    chk({rq, " new_ready"}, 64'(new_ready), 64'd1);
    @(negedge clk);
    new_valid = 1'b0;
    chk({rq, " req_valid"}, 64'(req_valid), 64'd1);
    chk({rq, " req_retry"}, 64'(req_retry), 64'd0);
    chk({rq, " req_tag"}, 64'(req_tag), 64'(exp_tag));
    chk({rq, " req_id"}, 64'(req_id), 64'(id));
    chk({rq, " req_addr"}, 64'(req_addr), 64'(addr));
  endtask

  task automatic respond(input logic [2:0] tag, input logic hit,
                         output logic dv, output logic [7:0] did, output logic pn);
    rsp_valid = 1'b1; rsp_tag = tag; rsp_hit = hit;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_hit = 1'b0;
    dv = done_valid; did = done_id; pn = panic;
  endtask

  task automatic fill(input logic [31:0] addr);
    fill_valid = 1'b1; fill_addr = addr;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic wait_retry(input logic [2:0] tag, input logic [7:0] id,
                            input logic [31:0] addr, input string rq);
    int n = 0;
    while (!req_valid && n < 12) begin
      @(negedge clk);
      n++;
    end
    chk({rq, " retry seen"}, 64'(req_valid), 64'd1);
    chk({rq, " retry flag"}, 64'(req_retry), 64'd1);
    chk({rq, " retry tag"}, 64'(req_tag), 64'(tag));
    chk({rq, " retry id"}, 64'(req_id), 64'(id));
    chk({rq, " retry addr"}, 64'(req_addr), 64'(addr));
    @(negedge clk);
  endtask

  task automatic quiet(input int n, input string rq);
    for (int i = 0; i < n; i++) begin
      chk({rq, " no request"}, 64'(req_valid), 64'd0);
      @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic [7:0]  id;
    logic [15:0] addr;
    logic [3:0]  nmiss;
    logic        pan;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{8'h03, 16'h0100, 4'd0, 1'b0},
    '{8'h07, 16'h0240, 4'd2, 1'b0},
    '{8'h09, 16'h0300, 4'd4, 1'b0},
    '{8'h0C, 16'h0400, 4'd5, 1'b1},
    '{8'h11, 16'h0580, 4'd6, 1'b1}
  };

  initial begin
    logic       dv, pn;
    logic [7:0] did;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 req_valid", 64'(req_valid), 64'd0);
    chk("R1 panic", 64'(panic), 64'd0);
    chk("R1 new_nack", 64'(new_nack), 64'd0);
    chk("R1 done_valid", 64'(done_valid), 64'd0);
    chk("R1 new_ready", 64'(new_ready), 64'd1);
    rst = 1'b0;
    @(negedge clk);

    // R2 R3 R4 R9 R10 R11 R12 table walk
    for (int v = 0; v < 5; v++) begin
      issue_new(VEC[v].id, 32'(VEC[v].addr), 3'd0, "R2");
      for (int m = 0; m < int'(VEC[v].nmiss); m++) begin
        respond(3'd0, 1'b0, dv, did, pn);
        chk("R4 no done on miss", 64'(dv), 64'd0);
        if (m == int'(VEC[v].nmiss) - 1) begin
          chk("R9 panic after misses", 64'(pn), 64'(VEC[v].pan));
          if (VEC[v].pan) begin
            new_valid = 1'b1; new_id = 8'hEE; new_addr = 32'hF000;
            #1;
            chk("R10 ready low", 64'(new_ready), 64'd0);
            @(negedge clk);
            new_valid = 1'b0;
            chk("R10 nack", 64'(new_nack), 64'd1);
            chk("R10 no request", 64'(req_valid), 64'd0);
          end
        end
        fill(32'(VEC[v].addr));
        wait_retry(3'd0, VEC[v].id, 32'(VEC[v].addr), "R11");
      end
      respond(3'd0, 1'b1, dv, did, pn);
      chk("R3 done", 64'(dv), 64'd1);
      chk("R3 done id", 64'(did), 64'(VEC[v].id));
      chk("R12 panic cleared", 64'(pn), 64'd0);
    end

    // R7 full file, R4 unrelated fill, R5 multi release in order
    for (int i = 0; i < 8; i++) issue_new(8'h40 + 8'(i), 32'h7000, 3'(i), "R7 fill up");
    for (int i = 0; i < 8; i++) begin
      respond(3'(i), 1'b0, dv, did, pn);
    end
    new_valid = 1'b1; new_id = 8'h55; new_addr = 32'h7800;
    #1;
    chk("R7 stalled", 64'(new_ready), 64'd0);
    @(negedge clk);
    new_valid = 1'b0;
    chk("R7 no request", 64'(req_valid), 64'd0);
    fill(32'h7100);
    quiet(5, "R4 other address");
    fill(32'h7000);
    for (int i = 0; i < 8; i++) wait_retry(3'(i), 8'h40 + 8'(i), 32'h7000, "R5 order");
    for (int i = 0; i < 8; i++) begin
      respond(3'(i), 1'b1, dv, did, pn);
      chk("R3 done id after release", 64'(did), 64'(8'h40 + 8'(i)));
    end

    // R8 retry beats new slice
    issue_new(8'h60, 32'h8000, 3'd0, "R8 setup");
    respond(3'd0, 1'b0, dv, did, pn);
    fill(32'h8000);
    @(negedge clk);
    new_valid = 1'b1; new_id = 8'h61; new_addr = 32'h8100;
    #1;
    chk("R8 new held", 64'(new_ready), 64'd0);
    @(negedge clk);
    chk("R8 retry first", 64'(req_retry), 64'd1);
    chk("R8 retry tag", 64'(req_tag), 64'd0);
    @(negedge clk);
    new_valid = 1'b0;
    chk("R8 new later", 64'(req_valid), 64'd1);
    chk("R8 new flag", 64'(req_retry), 64'd0);
    chk("R8 new id", 64'(req_id), 64'h61);
    respond(3'd0, 1'b1, dv, did, pn);
    respond(3'd1, 1'b1, dv, did, pn);
    chk("R3 second done", 64'(did), 64'h61);

    // R6 fill in the same cycle as the miss
    issue_new(8'h70, 32'h9000, 3'd0, "R6 setup");
    rsp_valid = 1'b1; rsp_tag = 3'd0; rsp_hit = 1'b0;
    fill_valid = 1'b1; fill_addr = 32'h9000;
    @(negedge clk);
    rsp_valid = 1'b0; fill_valid = 1'b0;
    wait_retry(3'd0, 8'h70, 32'h9000, "R6");
    respond(3'd0, 1'b1, dv, did, pn);

    // R13 stale response
    respond(3'd5, 1'b1, dv, did, pn);
    chk("R13 no done", 64'(dv), 64'd0);
    respond(3'd0, 1'b0, dv, did, pn);
    chk("R13 no panic", 64'(pn), 64'd0);

    // R11 R12 held retry during panic
    issue_new(8'h80, 32'hA000, 3'd0, "R11 owner");
    issue_new(8'h81, 32'hB000, 3'd1, "R11 other");
    respond(3'd1, 1'b0, dv, did, pn);
    respond(3'd0, 1'b0, dv, did, pn);
    for (int k = 0; k < 4; k++) begin
      fill(32'hA000);
      wait_retry(3'd0, 8'h80, 32'hA000, "R9 climb");
      respond(3'd0, 1'b0, dv, did, pn);
      chk("R9 threshold", 64'(pn), (k == 3) ? 64'd1 : 64'd0);
    end
    fill(32'hB000);
    quiet(6, "R11 held");
    fill(32'hA000);
    wait_retry(3'd0, 8'h80, 32'hA000, "R11 owner bypass");
    respond(3'd0, 1'b1, dv, did, pn);
    chk("R12 exit", 64'(pn), 64'd0);
    wait_retry(3'd1, 8'h81, 32'hB000, "R12 resume");
    respond(3'd1, 1'b1, dv, did, pn);
    chk("R12 other done", 64'(did), 64'h81);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule